// File: doc/BRIEF.md
# System-Management Memory Region Router

This block sits in a memory controller's address decode path. It decides, for each host address, whether the address falls in one of three protected system-management regions and whether that region is currently backed by DRAM. When it is not, the access goes out to the PCI bus. The three regions are:

- the legacy video-range window at 0xA0000–0xBFFFF;
- an alias of that DRAM area placed high, at 0x100A0000–0x100FFFFF;
- a segment carved from the top of installed DRAM, whose size software chooses.

The router also produces the DRAM address to use.

Two configuration bytes control the routing. One holds a global enable, an open bit, a sticky lock, a close bit and a base-segment field. The other holds the top-segment enable, its size code, an error flag and the high/legacy selector. The error flag is set by an external error event and cleared when software writes a 1 to it. The active-low system-management-active pin opens the regions while the processor is in management mode. The open bit opens them outside it, unless the lock has been set.

Routing is purely combinational on the address, the pin and the stored bytes. Configuration writes take effect on the clock edge that accepts them.

Top module: `smram_route_top`

## Requirements
- R1: After reset both configuration bytes read back as 0x00, and no address routes to DRAM, whatever the pin does.
- R2: Writing the control byte (cfgSel=0) stores: base segment in bits 2:0, global enable in bit 3, lock in bit 4, close in bit 5 and open in bit 6. Bit 7 reads 0. Writing the extended byte (cfgSel=1) stores: segment enable in bit 0, size code in bits 2:1 and high selector in bit 7. Bits 5:3 read 0.
- R3: Once lock has been written as 1, it stays 1 until reset, even when later writes carry 0 in bit 4.
- R4: While lock is 1, open reads 0. A write that sets lock, or follows it, cannot set open.
- R5: The error flag (extended bit 6) becomes 1 in the cycle after errEvt is high. A write of 1 to bit 6 clears it, and a write of 0 leaves it unchanged. errEvt wins over a clearing write in the same cycle.
- R6: With global enable 0, no address routes to DRAM.
- R7: With global enable 1, the regions are open when smiActN is low or open is 1. When smiActN is high and open is 0, nothing routes to DRAM.
- R8: When the regions are open and the high selector is 0, addresses 0xA0000–0xBFFFF route to DRAM with dramAddr equal to hostAddr.
- R9: When the regions are open and the high selector is 1, addresses 0x100A0000–0x100FFFFF route to DRAM with dramAddr = hostAddr − 0x10000000. The legacy window then goes to PCI.
- R10: The top segment is 128 KB shifted left by the size code. It spans host addresses 0x10000000+DRAM_BYTES−size to 0x10000000+DRAM_BYTES−1. When the regions are open and the segment is enabled, those addresses route to DRAM with dramAddr = hostAddr − 0x10000000, and the addresses one below and one above the span do not.
- R11: Addresses outside the three regions never route to DRAM. Whenever toDram is 0, dramAddr is 0.
- R12: A change of smiActN changes toDram and dramAddr within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 32 | Host address being decoded |
| smiActN | input | 1 | Low while the processor is in management mode |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgSel | input | 1 | 0 selects the control byte, 1 the extended byte |
| cfgWrData | input | 8 | Byte written |
| errEvt | input | 1 | Sets the error flag |
| toDram | output | 1 | Address is served from DRAM |
| dramAddr | output | 32 | Translated DRAM address, 0 when not routed |
| ctlRd | output | 8 | Current control byte |
| extRd | output | 8 | Current extended byte |

## Verification
Some properties are checked by assertions on every cycle:
- the lock cannot fall once it is set;
- open stays low under lock;
- the error flag obeys set and write-1-to-clear;
- a closed or disabled configuration never yields a DRAM route;
- any DRAM route lands inside installed DRAM, with a zero address otherwise.

The exact region bounds for each size code, the address translation for each region, the choice between the legacy and high windows, and the same-cycle reaction to the pin are shown only by the bench's scenarios against its reference model.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned ADDR_W = 32;

  localparam logic [ADDR_W-1:0] LEGACY_LO = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] LEGACY_HI = 32'h000B_FFFF;
  localparam logic [ADDR_W-1:0] ALIAS_LO  = 32'h100A_0000;
  localparam logic [ADDR_W-1:0] ALIAS_HI  = 32'h100F_FFFF;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'h1000_0000;
  localparam logic [ADDR_W-1:0] SEG_UNIT  = 32'h0002_0000;

  localparam int unsigned NUM_REGIONS = 3;
  localparam int unsigned IDX_LEGACY  = 0;
  localparam int unsigned IDX_ALIAS   = 1;
  localparam int unsigned IDX_SEG     = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic       legacyOn;
    logic       aliasOn;
    logic       segOn;
    logic [1:0] segCode;
  } routeStb_t;
endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       smiActN,
  input  logic       cfgWrEn,
  input  logic       cfgSel,
  input  logic [7:0] cfgWrData,
  input  logic       errEvt,
  output routeStb_t  stb,
  output logic [7:0] ctlRd,
  output logic [7:0] extRd
);
  logic [2:0] baseSegQ;
  logic       gEnQ, lockQ, closeQ, openQ;
  logic       segEnQ, highQ, errQ;
  logic [1:0] segCodeQ;
  logic       ctlWr, extWr, lockNext, regionsOpen;

  assign ctlWr    = cfgWrEn & ~cfgSel;
  assign extWr    = cfgWrEn & cfgSel;
  assign lockNext = lockQ | cfgWrData[4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSegQ <= '0;
      gEnQ     <= 1'b0;
      lockQ    <= 1'b0;
      closeQ   <= 1'b0;
      openQ    <= 1'b0;
    end else if (ctlWr) begin
      baseSegQ <= cfgWrData[2:0];
      gEnQ     <= cfgWrData[3];
      lockQ    <= lockNext;
      closeQ   <= cfgWrData[5];
      openQ    <= cfgWrData[6] & ~lockNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segEnQ   <= 1'b0;
      segCodeQ <= '0;
      highQ    <= 1'b0;
    end else if (extWr) begin
      segEnQ   <= cfgWrData[0];
      segCodeQ <= cfgWrData[2:1];
      highQ    <= cfgWrData[7];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       errQ <= 1'b0;
    else if (errEvt)                 errQ <= 1'b1;
    else if (extWr && cfgWrData[6])  errQ <= 1'b0;
  end

  assign regionsOpen  = gEnQ & (~smiActN | openQ);
  assign stb.legacyOn = regionsOpen & ~highQ;
  assign stb.aliasOn  = regionsOpen & highQ;
  assign stb.segOn    = regionsOpen & segEnQ;
  assign stb.segCode  = segCodeQ;

  assign ctlRd = {1'b0, openQ, closeQ, lockQ, gEnQ, baseSegQ};
  assign extRd = {highQ, errQ, 3'b000, segCodeQ, segEnQ};

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
  // R4
  open_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |-> !openQ);
  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEvt |=> errQ);
  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extWr && cfgWrData[6] && !errEvt) |=> !errQ);
endmodule

// File: rtl/smram_dp.sv
module smram_dp
  import smram_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DRAM_BYTES = 32'h0400_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  routeStb_t         stb,
  output logic              toDram,
  output logic [ADDR_W-1:0] dramAddr
);
  localparam logic [ADDR_W-1:0] SEG_END = HIGH_BASE + DRAM_BYTES;

  logic [ADDR_W-1:0] segSize;
  logic [ADDR_W-1:0] loBound [NUM_REGIONS];
  logic [ADDR_W-1:0] hiBound [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit, regionOn, sel;

  assign segSize = SEG_UNIT << stb.segCode;

  assign loBound[IDX_LEGACY] = LEGACY_LO;
  assign hiBound[IDX_LEGACY] = LEGACY_HI;
  assign loBound[IDX_ALIAS]  = ALIAS_LO;
  assign hiBound[IDX_ALIAS]  = ALIAS_HI;
  assign loBound[IDX_SEG]    = SEG_END - segSize;
  assign hiBound[IDX_SEG]    = SEG_END - 32'd1;

  assign regionOn[IDX_LEGACY] = stb.legacyOn;
  assign regionOn[IDX_ALIAS]  = stb.aliasOn;
  assign regionOn[IDX_SEG]    = stb.segOn;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign hit[i] = (hostAddr >= loBound[i]) && (hostAddr <= hiBound[i]);
    assign sel[i] = hit[i] & regionOn[i];
  end

  assign toDram = |sel;

  always_comb begin
    if (sel[IDX_LEGACY])                  dramAddr = hostAddr;
    else if (sel[IDX_ALIAS] | sel[IDX_SEG]) dramAddr = hostAddr - HIGH_BASE;
    else                                  dramAddr = '0;
  end

  // R10
  dram_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    toDram |-> (dramAddr < DRAM_BYTES));
  // R11
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !toDram |-> (dramAddr == '0));
endmodule

// File: rtl/smram_route_top.sv
module smram_route_top
  import smram_pkg::*;
#(
  parameter logic [31:0] DRAM_BYTES = 32'h0400_0000
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] hostAddr,
  input  logic        smiActN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWrData,
  input  logic        errEvt,
  output logic        toDram,
  output logic [31:0] dramAddr,
  output logic [7:0]  ctlRd,
  output logic [7:0]  extRd
);
  routeStb_t stb;

  smram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .smiActN(smiActN), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .errEvt(errEvt),
    .stb(stb), .ctlRd(ctlRd), .extRd(extRd)
  );

  smram_dp #(.DRAM_BYTES(DRAM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .stb(stb),
    .toDram(toDram), .dramAddr(dramAddr)
  );

  // R6
  disabled_pci_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRd[3] |-> !toDram);
  // R7
  closed_pci_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smiActN && !ctlRd[6]) |-> !toDram);
endmodule

// File: tb/smram_route_top_tb_top.sv
`timescale 1ns/100ps
module smram_route_top_tb_top;
  localparam longint DRAM = 64'h0400_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] hostAddr = '0;
  logic smiActN = 1'b1;
  logic cfgWrEn = 1'b0, cfgSel = 1'b0, errEvt = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic toDram;
  logic [31:0] dramAddr;
  logic [7:0] ctlRd, extRd;

  int nCmp = 0, nBad = 0;
  string curReq = "R1";
  logic [7:0] mCtl = 8'h00, mExt = 8'h00;

  smram_route_top #(.DRAM_BYTES(32'h0400_0000)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .smiActN(smiActN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData), .errEvt(errEvt),
    .toDram(toDram), .dramAddr(dramAddr), .ctlRd(ctlRd), .extRd(extRd)
  );

  always #2 clk = ~clk;

  // behavioural reference of the configuration bytes
  always @(posedge clk) begin
    if (!rstN) begin
      mCtl <= 8'h00;
      mExt <= 8'h00;
    end else begin
      logic lk, er;
      lk = mCtl[4];
      er = mExt[6];
      if (cfgWrEn && !cfgSel) begin
        lk = lk | cfgWrData[4];
        mCtl <= {1'b0, cfgWrData[6] & !lk, cfgWrData[5], lk, cfgWrData[3:0]};
      end
      if (errEvt) er = 1'b1;
      else if (cfgWrEn && cfgSel && cfgWrData[6]) er = 1'b0;
      if (cfgWrEn && cfgSel)
        mExt <= {cfgWrData[7], er, 3'b000, cfgWrData[2:1], cfgWrData[0]};
      else
        mExt <= {mExt[7], er, mExt[5:0]};
    end
  end

  task automatic expect_route(input logic [31:0] a, output logic exTo, output logic [31:0] exAddr);
    longint segSz, segLo, segHi, aa;
    bit open_;
    open_ = mCtl[3] && (!smiActN || mCtl[6]);
    segSz = 64'd131072 << mExt[2:1];
    segHi = 64'h1000_0000 + DRAM;
    segLo = segHi - segSz;
    aa = a;
    exTo = 1'b0;
    exAddr = '0;
    if (open_ && !mExt[7] && aa >= 64'hA0000 && aa <= 64'hBFFFF) begin
      exTo = 1'b1; exAddr = a;
    end else if (open_ && mExt[7] && aa >= 64'h100A0000 && aa <= 64'h100FFFFF) begin
      exTo = 1'b1; exAddr = a - 32'h1000_0000;
    end else if (open_ && mExt[0] && aa >= segLo && aa < segHi) begin
      exTo = 1'b1; exAddr = a - 32'h1000_0000;
    end
  endtask

  task automatic compare(input string req);
    logic eTo;
    logic [31:0] eAddr;
    expect_route(hostAddr, eTo, eAddr);
    nCmp++;
    if (toDram !== eTo || dramAddr !== eAddr || ctlRd !== mCtl || extRd !== mExt) begin
      nBad++;
      $display("FAIL %s addr=%h: actual to=%b da=%h ctl=%h ext=%h expected to=%b da=%h ctl=%h ext=%h",
               req, hostAddr, toDram, dramAddr, ctlRd, extRd, eTo, eAddr, mCtl, mExt);
    end
  endtask

  always @(negedge clk) compare(curReq);

  task automatic wrCfg(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a);
    @(posedge clk); #1;
    hostAddr = a;
  endtask

  bit done = 0;

  initial begin
    #800000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    smiActN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    probe(32'h000A_0000); probe(32'h100A_0000); probe(32'h13FF_FFFF);

    curReq = "R2";
    wrCfg(1'b0, 8'h27);
    wrCfg(1'b1, 8'hBF);
    probe(32'h0);
    wrCfg(1'b1, 8'h00);
    wrCfg(1'b0, 8'h00);

    curReq = "R7";
    wrCfg(1'b0, 8'h08);
    smiActN = 1'b1;
    probe(32'h000A_0000); probe(32'h000B_FFFF);

    curReq = "R12";
    @(posedge clk); #0.5 smiActN = 1'b0;
    #0.3 compare("R12");
    #0.2 smiActN = 1'b1;
    #0.3 compare("R12");

    curReq = "R8";
    smiActN = 1'b0;
    probe(32'h000A_0000); probe(32'h000B_FFFF); probe(32'h000B_1234);
    curReq = "R7";
    smiActN = 1'b1;
    wrCfg(1'b0, 8'h48);
    probe(32'h000A_8000);

    curReq = "R9";
    smiActN = 1'b0;
    wrCfg(1'b1, 8'h80);
    probe(32'h100A_0000); probe(32'h100F_FFFF); probe(32'h000A_0000);

    curReq = "R10";
    for (int c = 0; c < 4; c++) begin
      longint sz, lo;
      sz = 64'd131072 << c;
      lo = 64'h1400_0000 - sz;
      wrCfg(1'b1, {5'b00000, c[1:0], 1'b1});
      probe(32'(lo - 1)); probe(32'(lo)); probe(32'h13FF_FFFF); probe(32'h1400_0000);
    end

    curReq = "R11";
    wrCfg(1'b1, 8'h01);
    probe(32'h0009_FFFF); probe(32'h000C_0000); probe(32'h1009_FFFF);
    probe(32'h1010_0000); probe(32'hFFFF_FFFF);

    curReq = "R6";
    wrCfg(1'b0, 8'h40);
    probe(32'h000A_0000); probe(32'h13FF_FFFF);

    curReq = "R4";
    wrCfg(1'b0, 8'h58);
    probe(32'h000A_0000);
    curReq = "R3";
    wrCfg(1'b0, 8'h48);
    smiActN = 1'b1;
    probe(32'h000A_0000);
    wrCfg(1'b0, 8'h08);
    probe(32'h000A_0000);

    curReq = "R5";
    @(posedge clk); #1 errEvt = 1'b1;
    @(posedge clk); #1 errEvt = 1'b0;
    wrCfg(1'b1, 8'h01);
    wrCfg(1'b1, 8'h41);
    @(posedge clk); #1 errEvt = 1'b1;
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgWrData = 8'h40;
    @(posedge clk); #1 errEvt = 1'b0; cfgWrEn = 1'b0;
    probe(32'h0);

    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule